// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Controller

This block turns single requests from an internal master into timed bus cycles for an external asynchronous parallel device such as SRAM, NOR flash or a memory-mapped peripheral. A request carries an address, write data and a read/write flag. The controller runs the bus through an optional address phase, a setup phase, a strobe phase and a hold phase. It returns a one-cycle ready pulse with the read data. The length of every phase comes from configuration registers that are loaded while the controller is idle.

There are three bus modes. In the plain mode, eight data bits share nothing with the eight address bits. In the two multiplexed modes the address first travels on the shared 16-bit address/data bus, where the device captures it with an address-latch pulse. The two top address bits pick one of four banks. Each bank has its own chip-select line and its own enable bit. Every control line has its own polarity bit. A device ready input can stretch the strobe, bounded by a 32-cycle limit that can be switched off.

The state machine has eight states:
- `ST_IDLE` waits for a request.
- `ST_ADDR_SETUP` drives the address before the latch pulse.
- `ST_ALE` is the one-cycle latch pulse.
- `ST_ADDR_HOLD` keeps the address after the pulse.
- `ST_SETUP` is the access setup.
- `ST_STROBE` drives the read or write strobe and stretches it on wait.
- `ST_HOLD` keeps the chip select after the strobe.
- `ST_DONE` gives the ready pulse.

The transitions are:
- From `ST_IDLE`, a request to a disabled bank goes to `ST_DONE`.
- In a multiplexed mode, `ST_IDLE` goes to `ST_ADDR_SETUP`, or to `ST_ALE` when the address setup count is 0.
- Otherwise `ST_IDLE` goes to `ST_SETUP`, or to `ST_STROBE` when the setup count is 0.
- `ST_ADDR_SETUP` goes to `ST_ALE`.
- `ST_ALE` goes to `ST_ADDR_HOLD`, or onward to `ST_SETUP`/`ST_STROBE` when the hold count is 0.
- `ST_ADDR_HOLD` goes to `ST_SETUP` or `ST_STROBE`.
- `ST_SETUP` goes to `ST_STROBE`.
- `ST_STROBE` goes to `ST_HOLD`, or to `ST_DONE` when the hold count is 0.
- `ST_HOLD` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `amb_ctrl`

## Requirements
- R1: Bus modes and address placement.
  - `cfg_mode` 0 is plain 8-bit data: `ext_a` carries address bits [7:0] for the whole access, and read data is `ext_ad_i[7:0]` with zero upper byte.
  - `cfg_mode` 1 is multiplexed 16-bit data with a 16-bit address: read data is all of `ext_ad_i`, and `ext_a` is 0.
  - `cfg_mode` 2 is multiplexed 8-bit data with a 24-bit address: `ext_a` carries address bits [23:16] and read data is the low byte.
  - A load of mode 3 selects mode 0.
- R2: Address phase, multiplexed modes only.
  - The address phase is address-setup cycles, then exactly one cycle with the latch line active, then address-hold cycles.
  - During all of these cycles `ext_ad_o` carries address bits [15:0] and `ext_ad_oe` is 1.
- R3: Read access.
  - A read lasts read-setup cycles, then read-strobe cycles with the read line active, then read-hold cycles with only the chip select active.
  - `ext_ad_oe` is 0 throughout the read access phases.
  - Read data is captured on the last strobe cycle.
- R4: Write access.
  - A write uses the write-setup, write-strobe and write-hold counts in the same way, with the write line.
  - Write data is driven on `ext_ad_o` with `ext_ad_oe` at 1. In the 8-bit modes the upper byte is zero.
  - The read and write lines are never both active.
- R5: Pin polarity.
  - The bits of `cfg_pol` are [0] ready input, [1] latch, [2] write, [3] read, [4] chip selects.
  - A bit at 1 makes that line active-high; at 0 the line is active-low.
  - After reset all bits are 0, so an idle bus shows every output control pin at 1.
- R6: Ready wait.
  - With `cfg_ardy_en` at 1, the strobe continues past its programmed length while the ready input is inactive.
  - The strobe ends on the first cycle, at or after the programmed length, in which the ready input is active.
- R7: Wait limit.
  - Unless `cfg_ardy_no_timeout` is 1, a wait adds at most 32 cycles, so the strobe lasts at most the programmed length plus 32.
  - With the limit off, the strobe waits for the ready input without bound.
- R8: Bank decode.
  - Address bits [25:24] select bank k.
  - Only `ext_cs[k]` is driven active.
  - It is active for every cycle from the first address or setup cycle through the last hold cycle.
- R9: Disabled bank.
  - A request to a bank whose `cfg_bank_en` bit is 0 asserts no chip select, latch or strobe.
  - It raises `req_ready` in the cycle right after acceptance, with `rd_data` 0.
- R10: Reset values.
  - Mode 0, address hold 1, write hold 1, every other count 0.
  - Polarity bits 0, ready input and limit-off both 0, and only bank 0 enabled.
- R11: Handshake.
  - A request is accepted only in `ST_IDLE`; `req_valid` in any other state is ignored.
  - A count of 0 gives a one-cycle strobe.
  - `req_ready` is a one-cycle pulse in the cycle after the last hold cycle, or after the last strobe cycle when the hold count is 0.
  - `rd_data` is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load all cfg_* values (ignored while busy) |
| cfg_mode | input | 2 | Bus mode |
| cfg_addr_setup | input | CNT_W | Address setup cycles |
| cfg_addr_hold | input | CNT_W | Address hold cycles |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_strobe | input | CNT_W | Read strobe cycles |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_strobe | input | CNT_W | Write strobe cycles |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| cfg_pol | input | 5 | Line polarity bits |
| cfg_ardy_en | input | 1 | Enable ready-input wait |
| cfg_ardy_no_timeout | input | 1 | Turn off the wait limit |
| cfg_bank_en | input | NUM_BANKS | Per-bank enable |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24+BANK_W | Bank and device address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Access complete pulse |
| rd_data | output | 16 | Read data, valid with req_ready |
| ext_ad_o | output | 16 | Shared address/data bus out |
| ext_ad_oe | output | 1 | Shared bus output enable |
| ext_ad_i | input | 16 | Shared bus in |
| ext_a | output | 8 | Separate address lines |
| ext_ale | output | 1 | Address latch pin |
| ext_we | output | 1 | Write strobe pin |
| ext_re | output | 1 | Read strobe pin |
| ext_cs | output | NUM_BANKS | Chip-select pins |
| ext_ardy | input | 1 | Device ready pin |

## Verification
Two things can end the strobe in the same cycle: the ready input turning active, and the 32-cycle wait limit running out. The bench provokes this by holding the device's ready input back until exactly the strobe cycle in which the limit expires. It also places the ready input one cycle before that point and long after it. In each case it compares the counted strobe length, the completion cycle and the captured read data against values computed from the requirements. Data capture and the end of the strobe also coincide in every read, and the bench judges this through the returned data.

// File: rtl/amb_pkg.sv
package amb_pkg;

    localparam int DATA_W = 16;
    localparam int DEV_AW = 24;
    localparam int NARROW_W = 8;
    localparam int POL_W = 5;

    // polarity bit positions within cfg_pol
    localparam int POL_ARDY = 0;
    localparam int POL_ALE  = 1;
    localparam int POL_WE   = 2;
    localparam int POL_RE   = 3;
    localparam int POL_CS   = 4;

    typedef enum logic [1:0] {
        MODE_D8_A8      = 2'd0,
        MODE_D16_A16_MX = 2'd1,
        MODE_D8_A24_MX  = 2'd2
    } amb_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_ALE,
        ST_ADDR_HOLD,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } amb_state_e;

endpackage

// File: rtl/amb_cfg_regs.sv
module amb_cfg_regs
    import amb_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 busy,
    input  logic [1:0]           in_mode,
    input  logic [CNT_W-1:0]     in_as,
    input  logic [CNT_W-1:0]     in_ah,
    input  logic [CNT_W-1:0]     in_rs,
    input  logic [CNT_W-1:0]     in_rst,
    input  logic [CNT_W-1:0]     in_rh,
    input  logic [CNT_W-1:0]     in_ws,
    input  logic [CNT_W-1:0]     in_wst,
    input  logic [CNT_W-1:0]     in_wh,
    input  logic [POL_W-1:0]     in_pol,
    input  logic                 in_ardy_en,
    input  logic                 in_no_to,
    input  logic [NUM_BANKS-1:0] in_ben,
    output amb_mode_e            mode,
    output logic [CNT_W-1:0]     as_n,
    output logic [CNT_W-1:0]     ah_n,
    output logic [CNT_W-1:0]     rs_n,
    output logic [CNT_W-1:0]     rst_n_cnt,
    output logic [CNT_W-1:0]     rh_n,
    output logic [CNT_W-1:0]     ws_n,
    output logic [CNT_W-1:0]     wst_n,
    output logic [CNT_W-1:0]     wh_n,
    output logic [POL_W-1:0]     pol,
    output logic                 ardy_en,
    output logic                 no_to,
    output logic [NUM_BANKS-1:0] ben
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    amb_mode_e mode_dec;

    always_comb begin
        unique case (in_mode)
            2'd1:    mode_dec = MODE_D16_A16_MX;
            2'd2:    mode_dec = MODE_D8_A24_MX;
            default: mode_dec = MODE_D8_A8;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode      <= MODE_D8_A8;
            as_n      <= '0;
            ah_n      <= ONE;
            rs_n      <= '0;
            rst_n_cnt <= '0;
            rh_n      <= '0;
            ws_n      <= '0;
            wst_n     <= '0;
            wh_n      <= ONE;
            pol       <= '0;
            ardy_en   <= 1'b0;
            no_to     <= 1'b0;
            ben       <= NUM_BANKS'(1);
        end else if (load && !busy) begin
            mode      <= mode_dec;
            as_n      <= in_as;
            ah_n      <= in_ah;
            rs_n      <= in_rs;
            rst_n_cnt <= in_rst;
            rh_n      <= in_rh;
            ws_n      <= in_ws;
            wst_n     <= in_wst;
            wh_n      <= in_wh;
            pol       <= in_pol;
            ardy_en   <= in_ardy_en;
            no_to     <= in_no_to;
            ben       <= in_ben;
        end
    end

endmodule

// File: rtl/amb_bank_decode.sv
module amb_bank_decode #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic [BANK_W-1:0]    sel,
    input  logic [NUM_BANKS-1:0] en,
    input  logic                 on,
    output logic [NUM_BANKS-1:0] cs_act,
    output logic                 sel_en
);

    assign sel_en = en[sel];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_line
        assign cs_act[g] = on && en[g] && (sel == BANK_W'(g));
    end

endmodule

// File: rtl/amb_pin_drive.sv
module amb_pin_drive
    import amb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [POL_W-1:0]     pol,
    input  logic                 ale_act,
    input  logic                 we_act,
    input  logic                 re_act,
    input  logic [NUM_BANKS-1:0] cs_act,
    input  logic                 ext_ardy,
    output logic                 ext_ale,
    output logic                 ext_we,
    output logic                 ext_re,
    output logic [NUM_BANKS-1:0] ext_cs,
    output logic                 ardy_act
);

    // polarity bit 1 = active-high pin, 0 = active-low pin
    assign ext_ale  = ~(ale_act ^ pol[POL_ALE]);
    assign ext_we   = ~(we_act ^ pol[POL_WE]);
    assign ext_re   = ~(re_act ^ pol[POL_RE]);
    assign ardy_act = ~(ext_ardy ^ pol[POL_ARDY]);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
        assign ext_cs[g] = ~(cs_act[g] ^ pol[POL_CS]);
    end

endmodule

// File: rtl/amb_ctrl.sv
module amb_ctrl
    import amb_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int WAIT_LIMIT = 32,
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int REQ_AW = DEV_AW + BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [1:0]           cfg_mode,
    input  logic [CNT_W-1:0]     cfg_addr_setup,
    input  logic [CNT_W-1:0]     cfg_addr_hold,
    input  logic [CNT_W-1:0]     cfg_rd_setup,
    input  logic [CNT_W-1:0]     cfg_rd_strobe,
    input  logic [CNT_W-1:0]     cfg_rd_hold,
    input  logic [CNT_W-1:0]     cfg_wr_setup,
    input  logic [CNT_W-1:0]     cfg_wr_strobe,
    input  logic [CNT_W-1:0]     cfg_wr_hold,
    input  logic [4:0]           cfg_pol,
    input  logic                 cfg_ardy_en,
    input  logic                 cfg_ardy_no_timeout,
    input  logic [NUM_BANKS-1:0] cfg_bank_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [REQ_AW-1:0]    req_addr,
    input  logic [15:0]          req_wdata,
    output logic                 req_ready,
    output logic [15:0]          rd_data,
    output logic [15:0]          ext_ad_o,
    output logic                 ext_ad_oe,
    input  logic [15:0]          ext_ad_i,
    output logic [7:0]           ext_a,
    output logic                 ext_ale,
    output logic                 ext_we,
    output logic                 ext_re,
    output logic [NUM_BANKS-1:0] ext_cs,
    input  logic                 ext_ardy
);

    localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(WAIT_LIMIT);

    // ---------------- configuration ----------------
    amb_mode_e          mode;
    logic [CNT_W-1:0]   c_as, c_ah, c_rs, c_rst, c_rh, c_ws, c_wst, c_wh;
    logic [POL_W-1:0]   c_pol;
    logic               c_ardy_en, c_no_to;
    logic [NUM_BANKS-1:0] c_ben;

    amb_state_e state, nxt;
    logic busy;

    assign busy = (state != ST_IDLE);

    amb_cfg_regs #(.CNT_W(CNT_W), .NUM_BANKS(NUM_BANKS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(busy),
        .in_mode(cfg_mode), .in_as(cfg_addr_setup), .in_ah(cfg_addr_hold),
        .in_rs(cfg_rd_setup), .in_rst(cfg_rd_strobe), .in_rh(cfg_rd_hold),
        .in_ws(cfg_wr_setup), .in_wst(cfg_wr_strobe), .in_wh(cfg_wr_hold),
        .in_pol(cfg_pol), .in_ardy_en(cfg_ardy_en), .in_no_to(cfg_ardy_no_timeout),
        .in_ben(cfg_bank_en),
        .mode(mode), .as_n(c_as), .ah_n(c_ah), .rs_n(c_rs), .rst_n_cnt(c_rst),
        .rh_n(c_rh), .ws_n(c_ws), .wst_n(c_wst), .wh_n(c_wh), .pol(c_pol),
        .ardy_en(c_ardy_en), .no_to(c_no_to), .ben(c_ben)
    );

    // ---------------- latched request ----------------
    logic [REQ_AW-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic              is_wr;
    logic [CNT_W-1:0]  cnt, cnt_load;
    logic [WAIT_W-1:0] wait_cnt;

    logic              accept;
    logic              mux_mode;
    logic              sel_wr;
    logic [CNT_W-1:0]  sel_setup, sel_strobe, sel_hold;
    logic              req_hit;
    logic              ardy_act;
    logic              strobe_last, wait_more;
    logic [BANK_W-1:0] bank_sel;

    logic              ale_act, re_act, we_act, cs_on;
    logic [NUM_BANKS-1:0] cs_act;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign mux_mode = (mode != MODE_D8_A8);
    assign sel_wr   = (state == ST_IDLE) ? req_write : is_wr;
    assign sel_setup  = sel_wr ? c_ws  : c_rs;
    assign sel_strobe = sel_wr ? c_wst : c_rst;
    assign sel_hold   = sel_wr ? c_wh  : c_rh;
    assign bank_sel = (state == ST_IDLE) ? req_addr[REQ_AW-1 -: BANK_W]
                                         : addr_q[REQ_AW-1 -: BANK_W];

    amb_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .sel(bank_sel), .en(c_ben), .on(cs_on), .cs_act(cs_act), .sel_en(req_hit)
    );

    amb_pin_drive #(.NUM_BANKS(NUM_BANKS)) u_pins (
        .pol(c_pol), .ale_act(ale_act), .we_act(we_act), .re_act(re_act),
        .cs_act(cs_act), .ext_ardy(ext_ardy),
        .ext_ale(ext_ale), .ext_we(ext_we), .ext_re(ext_re), .ext_cs(ext_cs),
        .ardy_act(ardy_act)
    );

    // ---------------- wait decision ----------------
    assign strobe_last = (cnt == '0);
    assign wait_more   = c_ardy_en && !ardy_act && (c_no_to || (wait_cnt < WAIT_MAX));

    function automatic amb_state_e access_entry(input logic [CNT_W-1:0] setup);
        return (setup != '0) ? ST_SETUP : ST_STROBE;
    endfunction

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_hit)          nxt = ST_DONE;
                    else if (mux_mode)     nxt = (c_as != '0) ? ST_ADDR_SETUP : ST_ALE;
                    else                   nxt = access_entry(sel_setup);
                end
            end
            ST_ADDR_SETUP: if (cnt == '0) nxt = ST_ALE;
            ST_ALE:        nxt = (c_ah != '0) ? ST_ADDR_HOLD : access_entry(sel_setup);
            ST_ADDR_HOLD:  if (cnt == '0) nxt = access_entry(sel_setup);
            ST_SETUP:      if (cnt == '0) nxt = ST_STROBE;
            ST_STROBE: begin
                if (strobe_last && !wait_more)
                    nxt = (sel_hold != '0) ? ST_HOLD : ST_DONE;
            end
            ST_HOLD:       if (cnt == '0) nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            ST_ADDR_SETUP: cnt_load = c_as - ONE;
            ST_ADDR_HOLD:  cnt_load = c_ah - ONE;
            ST_SETUP:      cnt_load = sel_setup - ONE;
            ST_STROBE:     cnt_load = (sel_strobe == '0) ? '0 : sel_strobe - ONE;
            ST_HOLD:       cnt_load = sel_hold - ONE;
            default:       cnt_load = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)      cnt <= cnt_load;
            else if (cnt != '0)    cnt <= cnt - ONE;
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            is_wr    <= 1'b0;
            rd_data  <= '0;
            wait_cnt <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                is_wr   <= req_write;
                rd_data <= '0;
            end
            if (state == ST_STROBE && nxt != ST_STROBE && !is_wr) begin
                rd_data <= (mode == MODE_D16_A16_MX) ? ext_ad_i
                                                     : {8'h00, ext_ad_i[NARROW_W-1:0]};
            end
            if (state != ST_STROBE)
                wait_cnt <= '0;
            else if (strobe_last && wait_more && wait_cnt != WAIT_MAX)
                wait_cnt <= wait_cnt + WAIT_W'(1);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        ale_act   = (state == ST_ALE);
        re_act    = (state == ST_STROBE) && !is_wr;
        we_act    = (state == ST_STROBE) && is_wr;
        cs_on     = (state != ST_IDLE) && (state != ST_DONE);
        req_ready = (state == ST_DONE);
        ext_ad_o  = '0;
        ext_ad_oe = 1'b0;
        unique case (state)
            ST_ADDR_SETUP, ST_ALE, ST_ADDR_HOLD: begin
                ext_ad_o  = addr_q[15:0];
                ext_ad_oe = 1'b1;
            end
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                if (is_wr) begin
                    ext_ad_o  = (mode == MODE_D16_A16_MX) ? wdata_q
                                                          : {8'h00, wdata_q[NARROW_W-1:0]};
                    ext_ad_oe = 1'b1;
                end
            end
            default: ;
        endcase
        unique case (mode)
            MODE_D8_A8:     ext_a = addr_q[7:0];
            MODE_D8_A24_MX: ext_a = addr_q[DEV_AW-1 -: NARROW_W];
            default:        ext_a = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // R11
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R2
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_act |=> !ale_act);

    // R8
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re_act || we_act) |-> $onehot0(cs_act) && (cs_act != '0));

    // R9
    dis_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_hit) |=> req_ready && (cs_act == '0));

    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && !c_no_to) |-> (wait_cnt <= WAIT_MAX));

    // R4
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(re_act && we_act));

endmodule

// File: tb/amb_ctrl_tb.sv
module amb_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cfg_load = 1'b0;
    logic [1:0]  p_mode = 2'd2;
    logic [3:0]  p_as = 4'd7, p_ah = 4'd7, p_rs = 4'd7, p_rst = 4'd7, p_rh = 4'd7;
    logic [3:0]  p_ws = 4'd7, p_wst = 4'd7, p_wh = 4'd7;
    logic [4:0]  p_pol = 5'h1F;
    logic        p_ardy_en = 1'b1, p_no_to = 1'b1;
    logic [3:0]  p_ben = 4'hF;

    // effective configuration expected inside the design (reset values, R10)
    int          e_mode = 0, e_as = 0, e_ah = 1, e_rs = 0, e_rst = 0, e_rh = 0;
    int          e_ws = 0, e_wst = 0, e_wh = 1;
    logic [4:0]  e_pol = 5'h00;
    bit          e_ardy_en = 0, e_no_to = 0;
    logic [3:0]  e_ben = 4'b0001;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] rd_data, ext_ad_o;
    logic        ext_ad_oe;
    logic [15:0] dev_data = '0;
    logic [7:0]  ext_a;
    logic        ext_ale, ext_we, ext_re, ext_ardy;
    logic [3:0]  ext_cs;

    amb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(p_mode),
        .cfg_addr_setup(p_as), .cfg_addr_hold(p_ah), .cfg_rd_setup(p_rs),
        .cfg_rd_strobe(p_rst), .cfg_rd_hold(p_rh), .cfg_wr_setup(p_ws),
        .cfg_wr_strobe(p_wst), .cfg_wr_hold(p_wh), .cfg_pol(p_pol),
        .cfg_ardy_en(p_ardy_en), .cfg_ardy_no_timeout(p_no_to), .cfg_bank_en(p_ben),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_data(rd_data),
        .ext_ad_o(ext_ad_o), .ext_ad_oe(ext_ad_oe), .ext_ad_i(dev_data),
        .ext_a(ext_a), .ext_ale(ext_ale), .ext_we(ext_we), .ext_re(ext_re),
        .ext_cs(ext_cs), .ext_ardy(ext_ardy)
    );

    int checks = 0, errors = 0, cyc = 0, rdy_seen = 0, pushed = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got 0x%0h expected 0x%0h", tag, what, got, exp);
        end
    endtask

    // pin decoding by the bench's own view of polarity
    logic re_a, we_a, ale_a;
    logic [3:0] cs_a;
    assign re_a  = e_pol[3] ? ext_re  : ~ext_re;
    assign we_a  = e_pol[2] ? ext_we  : ~ext_we;
    assign ale_a = e_pol[1] ? ext_ale : ~ext_ale;
    assign cs_a  = e_pol[4] ? ext_cs  : ~ext_cs;

    // device ready model: active once strobe has lasted ardy_target cycles
    int scount = 0, ardy_target = 0;
    initial ext_ardy = 1'b0;
    always @(negedge clk) begin
        if (re_a || we_a) scount = scount + 1;
        ext_ardy <= e_pol[0] ? (scount >= ardy_target) : !(scount >= ardy_target);
    end

    typedef struct {
        int done; logic [15:0] rdata; int stb; bit wr; int ale;
        logic [3:0] csm; int csc; logic [15:0] ad; logic [7:0] a; logic [15:0] wd;
    } exp_t;
    exp_t  q[$];
    string tq[$];

    // monitor
    int m_rd = 0, m_wr = 0, m_ale = 0, m_csc = 0;
    logic [3:0]  m_csm = '0;
    logic [15:0] m_ad = '0, m_d = '0;
    logic [7:0]  m_a = '0;
    logic        m_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (re_a) m_rd++;
            if (we_a) m_wr++;
            if (re_a || we_a) begin m_a = ext_a; m_d = ext_ad_o; m_oe = ext_ad_oe; end
            if (ale_a) begin m_ale++; m_ad = ext_ad_o; end
            if (cs_a != '0) m_csc++;
            m_csm = m_csm | cs_a;
            if (req_ready) begin
                rdy_seen++;
                if (q.size() == 0) begin
                    chk(0, "R11", "unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    string t;
                    e = q.pop_front();
                    t = tq.pop_front();
                    chk(cyc == e.done, t, "completion cycle (R11)", cyc, e.done);
                    chk(rd_data == e.rdata, t, "read data (R3)", rd_data, e.rdata);
                    chk((e.wr ? m_wr : m_rd) == e.stb, t, "strobe cycles", e.wr ? m_wr : m_rd, e.stb);
                    chk((e.wr ? m_rd : m_wr) == 0, t, "other strobe cycles (R4)", e.wr ? m_rd : m_wr, 0);
                    chk(m_ale == e.ale, t, "latch pulses (R2)", m_ale, e.ale);
                    chk(m_csm == e.csm, t, "chip selects seen (R8)", m_csm, e.csm);
                    chk(m_csc == e.csc, t, "chip select cycles (R8)", m_csc, e.csc);
                    if (e.ale > 0) chk(m_ad == e.ad, t, "address on shared bus (R2)", m_ad, e.ad);
                    if (e.stb > 0) begin
                        chk(m_a == e.a, t, "address lines (R1)", m_a, e.a);
                        chk(m_oe == e.wr, t, "bus output enable", m_oe, e.wr);
                        if (e.wr) chk(m_d == e.wd, t, "write data (R4)", m_d, e.wd);
                    end
                end
                m_rd = 0; m_wr = 0; m_ale = 0; m_csc = 0; m_csm = '0;
            end
        end
    end

    task automatic load_cfg();
        @(negedge clk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        e_mode = (p_mode == 2'd3) ? 0 : int'(p_mode);
        e_as = p_as; e_ah = p_ah; e_rs = p_rs; e_rst = p_rst; e_rh = p_rh;
        e_ws = p_ws; e_wst = p_wst; e_wh = p_wh;
        e_pol = p_pol; e_ardy_en = p_ardy_en; e_no_to = p_no_to; e_ben = p_ben;
    endtask

    // driver: compute expectation from the requirements, push, issue request
    task automatic access(input bit wr, input logic [25:0] addr, input logic [15:0] wd,
                          input logic [15:0] dev, input int target, input bit dup,
                          input string tag);
        exp_t e;
        int   bank, s, st, h, ext;
        bit   mux;
        bank = int'(addr[25:24]);
        mux  = (e_mode != 0);
        e.wr = wr;
        e.ad = addr[15:0];
        e.a  = (e_mode == 0) ? addr[7:0] : (e_mode == 2) ? addr[23:16] : 8'h00;
        e.wd = (e_mode == 1) ? wd : {8'h00, wd[7:0]};
        if (!e_ben[bank]) begin
            e.stb = 0; e.ale = 0; e.csm = '0; e.csc = 0; e.rdata = '0;
            e.done = 0;
        end else begin
            s  = wr ? e_ws : e_rs;
            st = wr ? e_wst : e_rst;
            h  = wr ? e_wh : e_rh;
            if (st == 0) st = 1;
            if (e_ardy_en) begin
                ext = (target > st) ? target : st;
                if (!e_no_to && ext > st + 32) ext = st + 32;
                st = ext;
            end
            e.stb = st;
            e.ale = mux ? 1 : 0;
            e.csm = 4'b0001 << bank;
            e.csc = (mux ? e_as + 1 + e_ah : 0) + s + st + h;
            e.rdata = wr ? 16'h0000 : (e_mode == 1) ? dev : {8'h00, dev[7:0]};
            e.done = e.csc;
        end
        @(negedge clk);
        scount = 0;
        ardy_target = target;
        dev_data = dev;
        e.done = e.done + cyc + 1;
        q.push_back(e);
        tq.push_back(tag);
        pushed++;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (dup) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_pins(input string tag, input logic exp);
        @(negedge clk);
        chk(ext_cs == {4{exp}}, tag, "idle chip selects", ext_cs, {4{exp}});
        chk(ext_re == exp && ext_we == exp && ext_ale == exp, tag, "idle strobes/latch",
            {ext_re, ext_we, ext_ale}, {3{exp}});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        idle_pins("R5 reset polarity", 1'b1);
        chk(req_ready == 1'b0 && ext_ad_oe == 1'b0, "R11 reset", "ready/oe", {req_ready, ext_ad_oe}, 0);

        // R10: reset counts with mode 0, only bank 0 enabled
        access(0, {2'd0, 24'h000012}, 16'h0, 16'hA55A, 0, 0, "R10 default read");
        access(1, {2'd0, 24'h000034}, 16'h1234, 16'h0, 0, 0, "R10 default write");
        access(0, {2'd1, 24'h000056}, 16'h0, 16'hFFFF, 0, 0, "R10 R9 bank1 off at reset");

        // R2 R3 R4: 16-bit multiplexed mode
        p_mode = 2'd1; p_as = 4'd2; p_ah = 4'd1; p_rs = 4'd1; p_rst = 4'd3; p_rh = 4'd2;
        p_ws = 4'd0; p_wst = 4'd2; p_wh = 4'd1; p_pol = 5'h00;
        p_ardy_en = 1'b0; p_no_to = 1'b0; p_ben = 4'hF;
        load_cfg();
        access(0, {2'd1, 24'h00BEEF}, 16'h0, 16'hC0DE, 0, 0, "R3 R2 mux16 read");
        access(1, {2'd2, 24'h001357}, 16'hA5C3, 16'h0, 0, 0, "R4 R2 mux16 write");

        // R1: 24-bit address mode, zero counts, duplicate request while busy
        p_mode = 2'd2; p_as = 4'd0; p_ah = 4'd0; p_rs = 4'd0; p_rst = 4'd0; p_rh = 4'd0;
        load_cfg();
        access(0, {2'd3, 24'hABCDEF}, 16'h0, 16'h77F1, 0, 0, "R1 mode2 read");
        p_rst = 4'd3;
        load_cfg();
        access(0, {2'd3, 24'h12F00D}, 16'h0, 16'h1E2E, 0, 1, "R11 R1 busy request ignored");

        // R5: all lines active-high, R6 ready wait
        p_mode = 2'd0; p_rst = 4'd2; p_pol = 5'h1F; p_ardy_en = 1'b1;
        load_cfg();
        idle_pins("R5 active-high idle", 1'b0);
        access(0, {2'd0, 24'h000099}, 16'h0, 16'h0042, 5, 0, "R6 ready wait");
        access(1, {2'd0, 24'h0000AA}, 16'h0077, 16'h0, 1, 0, "R6 ready early");

        // R7: wait limit and its corner where ready meets the limit
        p_pol = 5'h00; p_rst = 4'd1;
        load_cfg();
        access(0, {2'd0, 24'h000001}, 16'h0, 16'h0011, 100, 0, "R7 timeout expiry");
        access(0, {2'd0, 24'h000002}, 16'h0, 16'h0022, 33, 0, "R7 ready on limit cycle");
        access(0, {2'd0, 24'h000003}, 16'h0, 16'h0033, 32, 0, "R7 ready before limit");
        p_no_to = 1'b1;
        load_cfg();
        access(0, {2'd0, 24'h000004}, 16'h0, 16'h0044, 60, 0, "R7 limit off");

        // R8 R9: bank enables
        p_ardy_en = 1'b0; p_no_to = 1'b0; p_ben = 4'b0101;
        load_cfg();
        access(1, {2'd1, 24'h000010}, 16'h5555, 16'h0, 0, 0, "R9 disabled bank write");
        access(0, {2'd3, 24'h000020}, 16'h0, 16'hFFFF, 0, 0, "R9 disabled bank read");
        access(0, {2'd2, 24'h000030}, 16'h0, 16'h00C8, 0, 0, "R8 bank2 select");

        repeat (4) @(negedge clk);
        chk(rdy_seen == pushed, "R11", "ready pulses", rdy_seen, pushed);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: R11 run did not complete, got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule